// File: doc/BRIEF.md
# Filter Output Duty Scaler

This block sits between a digital compensator filter and a PWM generator. It takes the filter's signed output and scales it by an unsigned multiplier to produce an unsigned high-resolution on-time count. The multiplier comes from one of four sources: a fixed scaling constant, the switching period, a feed-forward value taken from another filter, or a resonant duty value. With the period selected, a full-scale positive filter output maps to roughly the whole period. The other sources allow scaling that does not depend on the period, or let another loop modulate this one.

A small select register, written through a strobe, chooses the source. It starts on the scaling constant. Each valid filter sample is multiplied by the chosen source. A negative product is forced to zero. Otherwise the product is shifted down to an 18-bit count, in which 16 steps make one period-clock tick. The result and a valid strobe are registered and appear one clock after the sample.

Top module: `fds_top`

## Requirements
- R1: The select value picks the multiplier: 0 takes `mult_kscale`, 1 takes `mult_period`, 2 takes `mult_ffwd`, 3 takes `mult_reso`.
- R2: After reset the select register holds 0, so samples use `mult_kscale` until `sel_wr` is pulsed.
- R3: A `sel_wr` pulse loads `sel_in` into the select register. Samples accepted in later cycles use the new source. A sample accepted in the same cycle as the write still uses the previous source.
- R4: `filt_out` is 24-bit two's complement and every source is 14-bit unsigned. When their product is zero or positive, `on_time` equals the product divided by 2^19, rounded down.
- R5: When the product is negative, `on_time` is 0.
- R6: A filter value of 4194304 with source 2500 gives `on_time` = 20000. Its coarse part, bits 17:4, is 1250.
- R7: `out_valid` equals `in_valid` delayed by one clock. `on_time` changes only in the cycle after a valid sample and holds at all other times.
- R8: During and right after reset, `out_valid` and `on_time` are 0.
- R9: A filter value of 8388607 with source 16383 gives 262127, the largest possible output. A filter value of -8388608 gives 0 with every source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_wr | input | 1 | Strobe that loads `sel_in` into the select register |
| sel_in | input | 2 | New source select value |
| in_valid | input | 1 | Filter sample strobe |
| filt_out | input | 24 | Signed filter output |
| mult_kscale | input | 14 | Fixed scaling constant source |
| mult_period | input | 14 | Switching period source |
| mult_ffwd | input | 14 | Feed-forward source |
| mult_reso | input | 14 | Resonant duty source |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| on_time | output | 18 | High-resolution on-time count |

## Verification
The hardest case to reach is a select write in the same cycle as a valid sample, because the old and new sources must then differ visibly. The bench writes the select together with a sample whose sources are far apart, then sends a second sample, and the two results show which source each one used. The rail products are a second hard case: a maximum-positive or most-negative filter value combined with the largest source and with a zero source. The bench steps through every select value and applies all three extreme filter values to each. On top of these directed cases, random samples are sent with random select writes mixed in.

// File: rtl/fds_pkg.sv
package fds_pkg;
  typedef enum logic [1:0] {
    SRC_KSCALE = 2'd0,
    SRC_PERIOD = 2'd1,
    SRC_FFWD   = 2'd2,
    SRC_RESO   = 2'd3
  } src_sel_e;

  localparam int unsigned NUM_SRC = 4;
endpackage

// File: rtl/fds_sel_reg.sv
module fds_sel_reg
  import fds_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_wr,
  input  logic [1:0] sel_in,
  output src_sel_e   sel_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      sel_q <= SRC_KSCALE;
    else if (sel_wr) sel_q <= src_sel_e'(sel_in);
  end

  // R3: register holds without a write, loads on a write
  p_sel_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_wr |=> $stable(sel_q));
  p_sel_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> (sel_q == src_sel_e'($past(sel_in))));
endmodule

// File: rtl/fds_src_mux.sv
module fds_src_mux
  import fds_pkg::*;
#(
  parameter int unsigned MULT_W = 14
) (
  input  logic [NUM_SRC*MULT_W-1:0] src_bus,
  input  src_sel_e                  sel,
  output logic [MULT_W-1:0]         mult
);
  logic [MULT_W-1:0] lane [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_lane
    assign lane[g] = src_bus[g*MULT_W +: MULT_W];
  end

  always_comb mult = lane[sel];
endmodule

// File: rtl/fds_scale.sv
module fds_scale #(
  parameter int unsigned FILT_W = 24,
  parameter int unsigned MULT_W = 14,
  parameter int unsigned SHIFT  = 19,
  localparam int unsigned PROD_W = FILT_W + MULT_W,
  localparam int unsigned OUT_W  = PROD_W - 1 - SHIFT
) (
  input  logic [FILT_W-1:0] filt,
  input  logic [MULT_W-1:0] mult,
  output logic              prod_neg,
  output logic [OUT_W-1:0]  duty
);
  // signed filter times unsigned multiplier, exact in PROD_W bits
  function automatic logic signed [PROD_W-1:0] mul_su(
    input logic [FILT_W-1:0] a, input logic [MULT_W-1:0] b);
    logic signed [PROD_W-1:0] a_ext;
    logic signed [PROD_W-1:0] b_ext;
    a_ext = PROD_W'($signed(a));
    b_ext = PROD_W'({1'b0, b});
    return a_ext * b_ext;
  endfunction

  // floor at zero, then drop the sign bit and the SHIFT fraction bits
  function automatic logic [OUT_W-1:0] clamp_shift(
    input logic signed [PROD_W-1:0] p);
    if (p[PROD_W-1]) return '0;
    return p[PROD_W-2:SHIFT];
  endfunction

  logic signed [PROD_W-1:0] prod;

  always_comb begin
    prod     = mul_su(filt, mult);
    prod_neg = prod[PROD_W-1];
    duty     = clamp_shift(prod);
  end
endmodule

// File: rtl/fds_top.sv
module fds_top
  import fds_pkg::*;
#(
  parameter int unsigned FILT_W = 24,
  parameter int unsigned MULT_W = 14,
  parameter int unsigned SHIFT  = 19,
  localparam int unsigned OUT_W = FILT_W + MULT_W - 1 - SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_wr,
  input  logic [1:0]        sel_in,
  input  logic              in_valid,
  input  logic [FILT_W-1:0] filt_out,
  input  logic [MULT_W-1:0] mult_kscale,
  input  logic [MULT_W-1:0] mult_period,
  input  logic [MULT_W-1:0] mult_ffwd,
  input  logic [MULT_W-1:0] mult_reso,
  output logic              out_valid,
  output logic [OUT_W-1:0]  on_time
);
  localparam logic [63:0] MAX_OUT =
    (((64'd1 << (FILT_W-1)) - 64'd1) * ((64'd1 << MULT_W) - 64'd1)) >> SHIFT;

  src_sel_e                  sel_q;
  logic [MULT_W-1:0]         mult_pick;
  logic [NUM_SRC*MULT_W-1:0] src_bus;
  logic                      prod_neg;
  logic [OUT_W-1:0]          duty_c;

  assign src_bus = {mult_reso, mult_ffwd, mult_period, mult_kscale};

  fds_sel_reg u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_wr (sel_wr),
    .sel_in (sel_in),
    .sel_q  (sel_q)
  );

  fds_src_mux #(.MULT_W(MULT_W)) u_mux (
    .src_bus (src_bus),
    .sel     (sel_q),
    .mult    (mult_pick)
  );

  fds_scale #(.FILT_W(FILT_W), .MULT_W(MULT_W), .SHIFT(SHIFT)) u_scale (
    .filt     (filt_out),
    .mult     (mult_pick),
    .prod_neg (prod_neg),
    .duty     (duty_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      on_time   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) on_time <= duty_c;
    end
  end

  // R7: strobe delay and output hold
  p_valid_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(on_time));
  // R5: a negative filter sample never produces a nonzero count
  p_neg_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && filt_out[FILT_W-1]) |=> (on_time == '0));
  // R5: a negative product from the scaler is registered as zero
  p_prod_neg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && prod_neg) |=> (on_time == '0));
  // R9: the output never exceeds the rail product
  p_ceiling_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (64'(on_time) <= MAX_OUT));
endmodule

// File: tb/fds_top_tb.sv
module fds_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel_wr;
  logic [1:0]  sel_in;
  logic        in_valid;
  logic [23:0] filt_out;
  logic [13:0] mult_kscale, mult_period, mult_ffwd, mult_reso;
  logic        out_valid;
  logic [17:0] on_time;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int          sel_m;
  logic        exp_valid;
  logic [17:0] exp_on;

  always #5 clk = ~clk;

  fds_top u_dut (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_in(sel_in),
    .in_valid(in_valid), .filt_out(filt_out),
    .mult_kscale(mult_kscale), .mult_period(mult_period),
    .mult_ffwd(mult_ffwd), .mult_reso(mult_reso),
    .out_valid(out_valid), .on_time(on_time)
  );

  function automatic longint ref_scale(input int f, input int m);
    longint p;
    p = longint'(f) * longint'(m);
    if (p < 0) return 0;
    return p / 524288;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check({tag, " out_valid"}, longint'(out_valid), longint'(exp_valid));
    check({tag, " on_time"}, longint'(on_time), longint'(exp_on));
  endtask

  // one clock: check what the previous cycle produced, then drive this cycle
  task automatic cyc(input logic v, input int f, input int k, input int p,
                     input int ff, input int r, input logic w, input int s,
                     input string tag);
    int pick;
    @(negedge clk);
    compare(tag);
    in_valid    = v;
    filt_out    = f[23:0];
    mult_kscale = k[13:0];
    mult_period = p[13:0];
    mult_ffwd   = ff[13:0];
    mult_reso   = r[13:0];
    sel_wr      = w;
    sel_in      = s[1:0];
    case (sel_m)
      0: pick = k;
      1: pick = p;
      2: pick = ff;
      default: pick = r;
    endcase
    if (v) exp_on = 18'(ref_scale(f, pick));
    exp_valid = v;
    if (w) sel_m = s;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; sel_wr = 0; sel_in = 0; in_valid = 0; filt_out = 0;
    mult_kscale = 0; mult_period = 0; mult_ffwd = 0; mult_reso = 0;
    sel_m = 0; exp_valid = 0; exp_on = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R8 in reset");
    rst_n = 1'b1;

    // R8 right after reset, R2 default source is the scaling constant
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R8");
    cyc(1, 4194304, 1000, 2500, 300, 40, 0, 0, "R2");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R2");

    // R1 each encoding; R3 write in the same cycle as a sample
    cyc(1, 4194304, 1000, 2500, 300, 40, 1, 1, "R3");
    cyc(1, 4194304, 1000, 2500, 300, 40, 0, 0, "R3");
    cyc(0, 0, 0, 0, 0, 0, 1, 2, "R1");
    cyc(1, 4194304, 1000, 2500, 300, 40, 0, 0, "R1");
    cyc(0, 0, 0, 0, 0, 0, 1, 3, "R1");
    cyc(1, 4194304, 1000, 2500, 300, 40, 0, 0, "R1");
    cyc(0, 0, 0, 0, 0, 0, 1, 1, "R1");

    // R6 worked example, held for inspection
    cyc(1, 4194304, 77, 2500, 5, 6, 0, 0, "R6");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R6");
    check("R6 full count", longint'(on_time), 20000);
    check("R6 coarse count", longint'(on_time[17:4]), 1250);

    // R5 negative products
    cyc(1, -1, 1, 16383, 1, 1, 0, 0, "R5");
    cyc(1, -4194304, 1, 2500, 1, 1, 0, 0, "R5");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R7 hold");
    cyc(0, 1234567, 9, 9, 9, 9, 0, 0, "R7 hold");

    // R9 rail filter values under every source
    for (int s = 0; s < 4; s++) begin
      cyc(0, 0, 0, 0, 0, 0, 1, s, "R9");
      cyc(1, 8388607, 16383, 2500, 1, 0, 0, 0, "R9");
      cyc(1, -8388608, 16383, 2500, 1, 0, 0, 0, "R9");
      cyc(1, 0, 16383, 2500, 1, 0, 0, 0, "R9");
      cyc(1, 8388607, 16383, 16383, 16383, 16383, 0, 0, "R9");
    end

    // R4 random samples with occasional select writes and gaps
    for (int i = 0; i < 400; i++) begin
      logic [23:0] rf;
      rf = 24'($urandom);
      cyc(($urandom % 4) != 0, int'($signed(rf)),
          int'($urandom % 16384), int'($urandom % 16384),
          int'($urandom % 16384), int'($urandom % 16384),
          ($urandom % 8) == 0, int'($urandom % 4), "R4");
    end
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R4");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R7");
    done = 1;
    finish_run();
  end
endmodule